// File: doc/BRIEF.md
# Programming-mode entry sequencer

This controller brings a target device into its serial programming mode over a two-wire link: a clock line and a bidirectional data line. It controls the target's supply and its reset pin. It offers two entry methods, selected at each start. In power-cycle entry, the supply is switched on with both link lines floating and then left to settle for one millisecond. The first high-to-low handshake is then taken with the clock still floating. In reset-pin entry, the clock is driven low and the reset pin is pulsed, and the first vector follows at once.

The sequencer does not move bits itself. It requests a handshake from an external detector with a start pulse and gets a done/fail answer back. It requests a vector from an external shifter with a start pulse and a vector selector, and gets a done answer back. Vector 0 is the setup vector and vector 1 is the wait-and-poll-end vector.

Once the last vector has been shifted, the block reports success. It leaves the supply on and the clock driven low. If the detector reports a failed handshake, the block reports an init error, switches the supply off and floats both lines.

Top module: `prog_entry_seq`

## Requirements
- R1: After reset, pwr_en, tgt_rst, sclk_oe, sdata_oe, hs_start, vec_start, busy and done are all 0.
- R2: In power-cycle entry (mode=0), pwr_en goes high in the first cycle after start is taken. sclk_oe and sdata_oe both stay 0 from that cycle until the setup vector starts. pwr_en then stays high until the sequence ends.
- R3: In power-cycle entry, the first hs_start pulse comes exactly CLK_HZ/1000 cycles after the first cycle in which pwr_en is high, which is a 1 ms settle window.
- R4: The first handshake of a power-cycle entry is requested with hs_clk_en=0 and sclk_oe=0, so the clock floats. Every later handshake is requested with hs_clk_en=1 and sclk_oe=1.
- R5: The setup vector starts (vec_start=1 with vec_id=0) in the cycle after the first handshake is answered with hs_done=1 and hs_fail=0. From that cycle on, sclk_oe is 1. sdata_oe is 1 only from each vec_start cycle up to and including the cycle in which vec_done is seen, and 0 at all other times.
- R6: The sequence order is: setup vector, then a handshake with the clock enabled, then the wait-and-poll-end vector (vec_id=1), then done=1 with ok=1 one cycle after its vec_done. No handshake is requested after vector 1. In the pass state, pwr_en and sclk_oe stay 1.
- R7: In reset-pin entry (mode=1), tgt_rst is 1 for exactly RST_CYC cycles, starting in the first cycle after start. During that time sclk_oe=1, sdata_oe=0 and no handshake is requested. The setup vector starts in the cycle in which tgt_rst falls.
- R8: The setup vector starts no later than one cycle after its reference event, and always within CLK_HZ/1000 cycles of it. The reference event is the answer to the first handshake in power-cycle entry, and the release of reset in reset-pin entry.
- R9: If a handshake is answered with hs_fail=1, then done=1 and ok=0 in the next cycle. In that cycle pwr_en, sclk_oe, sdata_oe and tgt_rst are all 0, and no further vector is requested.
- R10: start is ignored while busy=1, whatever the value of mode. start is accepted again once done=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an entry sequence (taken when not busy) |
| mode | input | 1 | Entry method: 0 power-cycle, 1 reset-pin |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished; held until next start |
| ok | output | 1 | With done: 1 pass, 0 init error |
| pwr_en | output | 1 | Target supply enable |
| tgt_rst | output | 1 | Target reset pin, active high |
| sclk_oe | output | 1 | Drive clock line (low when not shifting) |
| sdata_oe | output | 1 | Drive data line (while a vector shifts) |
| hs_start | output | 1 | One-cycle request to the handshake detector |
| hs_clk_en | output | 1 | Detector may toggle the clock during this handshake |
| hs_done | input | 1 | Detector finished |
| hs_fail | input | 1 | With hs_done: the handshake timed out |
| vec_start | output | 1 | One-cycle request to the vector shifter |
| vec_id | output | 1 | Vector to shift: 0 setup, 1 wait-and-poll-end |
| vec_done | input | 1 | Shifter finished |

## Verification
The hardest case to reach is a handshake failure that comes only after the first handshake has already passed and a vector has been shifted. That case is the one where the cleanup of the supply and both lines could go wrong. The bench models the detector and the shifter inside its own cycle loop. It sweeps their response latencies and, per run, the index of the handshake that should fail. This covers every failure point in both entry methods. Each run also pulses start with the opposite mode while the sequence is busy, so any restart would show up as a timing mismatch against the arithmetically predicted schedule.

// File: rtl/prog_entry_seq.sv
module prog_entry_seq #(
  parameter int CLK_HZ  = 125_000_000,
  parameter int RST_CYC = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mode,
  output logic busy,
  output logic done,
  output logic ok,
  output logic pwr_en,
  output logic tgt_rst,
  output logic sclk_oe,
  output logic sdata_oe,
  output logic hs_start,
  output logic hs_clk_en,
  input  logic hs_done,
  input  logic hs_fail,
  output logic vec_start,
  output logic vec_id,
  input  logic vec_done
);
  localparam int CYC_MS = CLK_HZ / 1000;
  localparam int CMAX   = (CYC_MS > RST_CYC) ? CYC_MS : RST_CYC;
  localparam int CW     = $clog2(CMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SET, S_RST, S_ACQG, S_ACQW, S_V1G, S_V1W,
    S_H2G, S_H2W, S_V2G, S_V2W, S_OK, S_ERR
  } st_t;

  st_t state;
  logic [CW-1:0] cnt;
  logic powered;

  wire idle_like = (state == S_IDLE) || (state == S_OK) || (state == S_ERR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      powered <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_OK, S_ERR:
          if (start) begin
            powered <= 1'b1;
            cnt     <= '0;
            state   <= mode ? S_RST : S_SET;
          end
        S_SET:
          if (cnt == CW'(CYC_MS - 1)) state <= S_ACQG;
          else cnt <= cnt + 1'b1;
        S_RST:
          if (cnt == CW'(RST_CYC - 1)) state <= S_V1G;
          else cnt <= cnt + 1'b1;
        S_ACQG: state <= S_ACQW;
        S_ACQW:
          if (hs_done) begin
            if (hs_fail) begin state <= S_ERR; powered <= 1'b0; end
            else state <= S_V1G;
          end
        S_V1G: state <= S_V1W;
        S_V1W: if (vec_done) state <= S_H2G;
        S_H2G: state <= S_H2W;
        S_H2W:
          if (hs_done) begin
            if (hs_fail) begin state <= S_ERR; powered <= 1'b0; end
            else state <= S_V2G;
          end
        S_V2G: state <= S_V2W;
        S_V2W: if (vec_done) state <= S_OK;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = !idle_like;
  assign done      = (state == S_OK) || (state == S_ERR);
  assign ok        = (state == S_OK);
  assign pwr_en    = powered;
  assign tgt_rst   = (state == S_RST);
  assign sdata_oe  = (state == S_V1G) || (state == S_V1W) || (state == S_V2G) || (state == S_V2W);
  assign sclk_oe   = (state == S_RST) || sdata_oe || (state == S_H2G) || (state == S_H2W) || (state == S_OK);
  assign hs_start  = (state == S_ACQG) || (state == S_H2G);
  assign hs_clk_en = (state == S_H2G) || (state == S_H2W);
  assign vec_start = (state == S_V1G) || (state == S_V2G);
  assign vec_id    = (state == S_V2G) || (state == S_V2W);

  logic [CW-1:0] pwr_age;
  logic          dl_arm;
  logic [CW-1:0] dl_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_en) pwr_age <= '0;
    else if (pwr_age != CW'(CYC_MS)) pwr_age <= pwr_age + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl_arm <= 1'b0;
      dl_cnt <= '0;
    end else if (vec_start) begin
      dl_arm <= 1'b0;
    end else if ((state == S_ACQW && hs_done && !hs_fail) ||
                 (state == S_RST && cnt == CW'(RST_CYC - 1))) begin
      dl_arm <= 1'b1;
      dl_cnt <= '0;
    end else if (dl_arm && dl_cnt != CW'(CYC_MS)) begin
      dl_cnt <= dl_cnt + 1'b1;
    end
  end

  assert_float_before_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr_en) && !tgt_rst) |-> (!sclk_oe && !sdata_oe));
  assert_settle_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_start && !sclk_oe) |-> (pwr_age >= CW'(CYC_MS)));
  assert_acquire_no_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_start && !sclk_oe) |-> !hs_clk_en);
  assert_no_handshake_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_start && vec_id) |=> !hs_start);
  assert_setup_follows_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_rst) |-> (vec_start && !vec_id));
  assert_first_vector_deadline_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dl_arm |-> (dl_cnt < CW'(CYC_MS)));
  assert_error_cleanup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !ok) |-> (!pwr_en && !sclk_oe && !sdata_oe && !tgt_rst));
endmodule

// File: tb/prog_entry_seq_bench.sv
module prog_entry_seq_bench;
  localparam int CLK_HZ = 8000;
  localparam int RSTC   = 3;
  localparam int C      = CLK_HZ / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0;
  logic hs_done = 1'b0, hs_fail = 1'b0, vec_done = 1'b0;
  logic busy, done, ok, pwr_en, tgt_rst, sclk_oe, sdata_oe;
  logic hs_start, hs_clk_en, vec_start, vec_id;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  prog_entry_seq #(.CLK_HZ(CLK_HZ), .RST_CYC(RSTC)) u_prog_entry_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .busy(busy), .done(done), .ok(ok), .pwr_en(pwr_en), .tgt_rst(tgt_rst),
    .sclk_oe(sclk_oe), .sdata_oe(sdata_oe), .hs_start(hs_start),
    .hs_clk_en(hs_clk_en), .hs_done(hs_done), .hs_fail(hs_fail),
    .vec_start(vec_start), .vec_id(vec_id), .vec_done(vec_done));

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int m, input int lh, input int lv, input int kf);
    int ehs1, ev1, ehs2, ev2, td;
    int hs_due, vec_due, nhs, first_v;
    int mm_pwr, mm_sclk, mm_sd, mm_rst, mm_hs, mm_clk, mm_vec, mm_vid, mm_busy;
    bit win;
    mm_pwr = 0; mm_sclk = 0; mm_sd = 0; mm_rst = 0; mm_hs = 0;
    mm_clk = 0; mm_vec = 0; mm_vid = 0; mm_busy = 0;
    hs_due = -1; vec_due = -1; nhs = 0; first_v = -1;
    if (m == 0) begin
      ehs1 = C; ev1 = ehs1 + lh + 1;
    end else begin
      ehs1 = -100; ev1 = RSTC;
    end
    ehs2 = ev1 + lv + 1; ev2 = ehs2 + lh + 1;
    if (kf == 0) td = ev2 + lv + 1;
    else if (m == 0 && kf == 1) td = ehs1 + lh + 1;
    else td = ehs2 + lh + 1;

    @(negedge clk); start = 1'b1; mode = m[0];
    for (int t = 0; t <= td + 1; t++) begin
      @(negedge clk);
      start = 1'b0; hs_done = 1'b0; hs_fail = 1'b0; vec_done = 1'b0;
      if (t == 2) begin start = 1'b1; mode = ~m[0]; end
      if (t < td) begin
        // R2, R9: supply held during the sequence
        if (pwr_en !== 1'b1) mm_pwr++;
        // R5, R7: clock drive
        if (sclk_oe !== ((m == 1) || (t >= ev1))) mm_sclk++;
        win = (t >= ev1 && t <= ev1 + lv) || (t >= ev2 && t <= ev2 + lv);
        if (sdata_oe !== win) mm_sd++;
        if (tgt_rst !== ((m == 1) && (t < RSTC))) mm_rst++;
        if (hs_start !== ((t == ehs1) || (t == ehs2))) mm_hs++;
        if (hs_start && (hs_clk_en !== (t == ehs2) || sclk_oe !== (t == ehs2) && m == 0)) mm_clk++;
        if (vec_start !== ((t == ev1) || (t == ev2))) mm_vec++;
        if (vec_start && vec_id !== (t == ev2)) mm_vid++;
        if (busy !== 1'b1 || done !== 1'b0) mm_busy++;
        if (vec_start && first_v < 0) first_v = t;
        if (hs_start) begin hs_due = t + lh; nhs++; end
        if (vec_start) vec_due = t + lv;
        if (t == hs_due) begin hs_done = 1'b1; hs_fail = (nhs == kf); end
        if (t == vec_due) vec_done = 1'b1;
      end else begin
        chk(done === 1'b1, "R6/R9 done", int'(done), 1);
        chk(busy === 1'b0, "R10 busy at end", int'(busy), 0);
        chk(ok === (kf == 0), "R6/R9 ok", int'(ok), int'(kf == 0));
        if (kf == 0)
          chk(pwr_en === 1'b1 && sclk_oe === 1'b1 && sdata_oe === 1'b0 && tgt_rst === 1'b0,
              "R6 pass hold", int'({pwr_en, sclk_oe, sdata_oe, tgt_rst}), 12);
        else
          chk({pwr_en, sclk_oe, sdata_oe, tgt_rst} === 4'b0, "R9 cleanup",
              int'({pwr_en, sclk_oe, sdata_oe, tgt_rst}), 0);
        chk(hs_start === 1'b0 && vec_start === 1'b0, "R6/R9 idle after",
            int'({hs_start, vec_start}), 0);
      end
    end
    chk(mm_pwr == 0, "R2 pwr_en", mm_pwr, 0);
    chk(mm_sclk == 0, "R5 sclk_oe", mm_sclk, 0);
    chk(mm_sd == 0, "R5 sdata_oe", mm_sd, 0);
    chk(mm_rst == 0, "R7 tgt_rst", mm_rst, 0);
    chk(mm_hs == 0, "R3 hs_start timing", mm_hs, 0);
    chk(mm_clk == 0, "R4 handshake clock", mm_clk, 0);
    chk(mm_vec == 0, "R6 vec_start timing", mm_vec, 0);
    chk(mm_vid == 0, "R6 vec_id", mm_vid, 0);
    chk(mm_busy == 0, "R10 busy/start ignored", mm_busy, 0);
    if (ev1 < td)
      chk(first_v == ((m == 1) ? RSTC : ehs1 + lh + 1) && first_v - ((m == 1) ? RSTC : ehs1 + lh) <= C,
          "R8 first vector deadline", first_v, (m == 1) ? RSTC : ehs1 + lh + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({pwr_en, tgt_rst, sclk_oe, sdata_oe, hs_start, vec_start, busy, done} === 8'b0,
        "R1 reset state", int'({pwr_en, tgt_rst, sclk_oe, sdata_oe, hs_start, vec_start, busy, done}), 0);
    for (int m = 0; m < 2; m++)
      for (int lh = 1; lh <= 3; lh++)
        for (int lv = 1; lv <= 3; lv++)
          for (int kf = 0; kf <= 2 - m; kf++)
            run(m, lh, lv, kf);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule